// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a down-counting timer that has to be refreshed inside a time window. Software writes one control byte. The top bit of that byte turns the watchdog on. The low seven bits load the count. Once the watchdog runs, a prescaler divides the system clock, and each prescaled tick lowers the count by one. The count is readable at any time. A separate window value sets how high the count may still be when a refresh arrives.

A one-cycle reset request is raised in three cases:
- The count's top bit drops. With the default width this is the step from 0x40 to 0x3F.
- Software refreshes too early, while the count is still above the window value.
- Software writes a control value whose counter top bit is zero while the watchdog is, or becomes, active.

After the request fires, the block returns to its reset state. The system reset logic outside the block stretches the pulse and drives the pin.

Top module: `window_watchdog`

## Requirements
- R1: After reset the count reads 0x7F, the watchdog is stopped, the reset request is low and the window value is 0x7F.
- R2: A control write loads the count from bits 6..0 of `wdata`, and bit 7 set starts the watchdog. While stopped, a control write never raises a request when bit 7 is clear. While stopped, the count does not change between writes.
- R3: While running, the count drops by one every DIV clock cycles. An accepted control write restarts that DIV-cycle interval from zero.
- R4: The count never steps from 0x40 to 0x3F. The tick that would do so raises the reset request instead. Writing 0xC0 raises it after exactly DIV cycles. Writing 0xC8 raises it after 9·DIV cycles.
- R5: A control write while running, with the current count greater than the window value, raises the reset request.
- R6: A control write whose bit 6 is 0 raises the reset request when the watchdog is running or bit 7 of that write is 1.
- R7: With the window value at 0x7F, a refresh is accepted at any count. For example, 0xDB loads 0x5B.
- R8: Once running, the watchdog stops only through a reset request or system reset. A control write with bit 7 clear leaves it running.
- R9: The reset request is a registered pulse. It is high for the one cycle after the offending clock edge. In that same cycle the count is 0x7F, the window is 0x7F and the watchdog is stopped.
- R10: When a control write and a prescaler tick fall on the same edge, the write takes effect and the tick is dropped.
- R11: A refresh made with the count at or below the window value is accepted without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control write strobe: enable bit and count |
| win_we | input | 1 | Window write strobe |
| wdata | input | CW+1 | Write data; bit CW is the enable bit, bits CW-1..0 are the count or window |
| count_o | output | CW | Live count value |
| running_o | output | 1 | Watchdog is running |
| sys_rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench aims at the exact cycle of the underflow request for the 0xC0 and 0xC8 loads. A prescaler that is off by one moves that pulse by a cycle, and a compare against 0x3F instead of the drop from 0x40 lets the count show a forbidden value. It also refreshes on the very edge of a tick. A design that lets the tick win would show a count one lower, or fire a false underflow. The remaining targets are early refreshes, refreshes at the window boundary, writes that clear bit 6, and writes that try to stop the watchdog. If the compare used ≥ instead of >, a boundary refresh would raise a request. If the enable bit could be cleared, the count would freeze. A long constrained-random run is checked cycle by cycle against a model in the bench.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [1:0] {
      FLT_NONE      = 2'd0,
      FLT_UNDERFLOW = 2'd1,
      FLT_EARLY     = 2'd2,
      FLT_TOPBIT    = 2'd3
   } fault_e;

   function automatic logic is_fault(input fault_e k);
      return k != FLT_NONE;
   endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int DIV = 12288
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (!run || restart) begin
               pre_q <= '0;
            end else if (pre_q == LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = run && (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_window.sv
module wdg_window #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          we,
   input  logic [CW-1:0] wval,
   input  logic [CW-1:0] cnt,
   output logic [CW-1:0] win,
   output logic          too_early
);
   localparam logic [CW-1:0] ONES = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= ONES;
      end else if (clear) begin
         win <= ONES;
      end else if (we) begin
         win <= wval;
      end
   end

   assign too_early = cnt > win;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [CW:0]   load_val,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          en
);
   localparam logic [CW-1:0] ONES = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONES;
         en  <= 1'b0;
      end else if (clear) begin
         cnt <= ONES;
         en  <= 1'b0;
      end else if (load) begin
         cnt <= load_val[CW-1:0];
         en  <= en | load_val[CW];
      end else if (dec) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdg_fault.sv
module wdg_fault
   import wdg_pkg::*;
#(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW:0]   wval,
   input  logic          en,
   input  logic [CW-1:0] cnt,
   input  logic          too_early,
   input  logic          tick,
   output fault_e        kind,
   output logic          fault,
   output logic          load,
   output logic          dec,
   output logic          rst_req
);
   localparam logic [CW-1:0] HALF = CW'(1) << (CW - 1);

   logic live_after;
   assign live_after = en | wval[CW];

   always_comb begin
      kind = FLT_NONE;
      if (wr) begin
         if (live_after && !wval[CW-1]) begin
            kind = FLT_TOPBIT;
         end else if (en && too_early) begin
            kind = FLT_EARLY;
         end
      end else if (en && tick && cnt == HALF) begin
         kind = FLT_UNDERFLOW;
      end
   end

   assign fault = is_fault(kind);
   assign load  = wr && !fault;
   assign dec   = en && tick && !wr && !fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
      end else begin
         rst_req <= fault;
      end
   end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
   import wdg_pkg::*;
#(
   parameter int CW  = 7,
   parameter int DIV = 12288
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic          win_we,
   input  logic [CW:0]   wdata,
   output logic [CW-1:0] count_o,
   output logic          running_o,
   output logic          sys_rst_req_o
);
   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("window_watchdog: CW must lie in 2..16");
      end
      if (DIV < 1) begin : g_bad_div
         $error("window_watchdog: DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] win_q;
   logic          en_q;
   logic          tick;
   logic          too_early;
   logic          fault;
   logic          load;
   logic          dec;
   logic          rst_req;
   fault_e        kind;

   wdg_prescaler #(.DIV(DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (load | fault),
      .tick    (tick)
   );

   wdg_window #(.CW(CW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (fault),
      .we        (win_we),
      .wval      (wdata[CW-1:0]),
      .cnt       (cnt_q),
      .win       (win_q),
      .too_early (too_early)
   );

   wdg_fault #(.CW(CW)) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctrl_we),
      .wval      (wdata),
      .en        (en_q),
      .cnt       (cnt_q),
      .too_early (too_early),
      .tick      (tick),
      .kind      (kind),
      .fault     (fault),
      .load      (load),
      .dec       (dec),
      .rst_req   (rst_req)
   );

   wdg_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (fault),
      .load     (load),
      .load_val (wdata),
      .dec      (dec),
      .cnt      (cnt_q),
      .en       (en_q)
   );

   assign count_o       = cnt_q;
   assign running_o     = en_q;
   assign sys_rst_req_o = rst_req;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
   parameter int CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctrl_we,
   input logic [CW:0]   wdata,
   input logic [CW-1:0] count_o,
   input logic          running_o,
   input logic          sys_rst_req_o,
   input logic [CW-1:0] win
);
   localparam logic [CW-1:0] ONES = '1;

   assert_alive_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      running_o |-> count_o[CW-1]);

   assert_early_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && ctrl_we && count_o > win) |=> sys_rst_req_o);

   assert_topbit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && (running_o || wdata[CW]) && !wdata[CW-1]) |=> sys_rst_req_o);

   assert_sticky_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      running_o |=> (running_o || sys_rst_req_o));

   assert_clean_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req_o |-> (!running_o && count_o == ONES && win == ONES));

   assert_frozen_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_o && !ctrl_we) |=> $stable(count_o));

   assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !ctrl_we) |=>
         (sys_rst_req_o || count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
endmodule

bind window_watchdog wdg_checker #(.CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctrl_we       (ctrl_we),
   .wdata         (wdata),
   .count_o       (count_o),
   .running_o     (running_o),
   .sys_rst_req_o (sys_rst_req_o),
   .win           (win_q)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
   localparam int DIV = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_we = 1'b0;
   logic       win_we = 1'b0;
   logic [7:0] wdata = '0;
   logic [6:0] count_o;
   logic       running_o;
   logic       sys_rst_req_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   window_watchdog #(.CW(7), .DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .win_we(win_we),
      .wdata(wdata), .count_o(count_o), .running_o(running_o),
      .sys_rst_req_o(sys_rst_req_o)
   );

   // reference model built from the requirements
   logic [6:0] m_cnt, m_win;
   logic       m_en, m_rst;
   int         m_pre;
   logic       m_tick, m_flt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 7'h7F; m_win <= 7'h7F; m_en <= 1'b0; m_rst <= 1'b0; m_pre <= 0;
      end else begin
         m_tick = m_en && (m_pre == DIV - 1);
         m_flt = 1'b0;
         if (ctrl_we && (m_en || wdata[7]) && !wdata[6]) m_flt = 1'b1;
         if (ctrl_we && m_en && m_cnt > m_win) m_flt = 1'b1;
         if (!ctrl_we && m_tick && m_cnt == 7'h40) m_flt = 1'b1;
         m_rst <= m_flt;
         if (m_flt) begin
            m_cnt <= 7'h7F; m_win <= 7'h7F; m_en <= 1'b0; m_pre <= 0;
         end else begin
            if (win_we) m_win <= wdata[6:0];
            if (ctrl_we) begin
               m_cnt <= wdata[6:0];
               m_en  <= m_en | wdata[7];
               m_pre <= 0;
            end else if (m_en) begin
               m_pre <= m_tick ? 0 : m_pre + 1;
               if (m_tick) m_cnt <= m_cnt - 7'd1;
            end
         end
      end
   end

   function automatic bit in_window(input logic [6:0] c, input logic [6:0] w);
      return c <= w;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every cycle, compare with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 count vs model", count_o, m_cnt);
         chk("R8 running vs model", running_o, m_en);
         chk("R9 request vs model", sys_rst_req_o, m_rst);
      end
   end

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_we = 1'b1; wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic wr_win(input logic [6:0] v);
      win_we = 1'b1; wdata = {1'b0, v};
      @(negedge clk);
      win_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int r;
      r = $urandom(32'd2024);
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count_o, 7'h7F);
      chk("R1 running", running_o, 0);
      chk("R1 request", sys_rst_req_o, 0);

      // R2 load while stopped, no request, no counting
      wr_ctrl(8'h25);
      chk("R2 request", sys_rst_req_o, 0);
      chk("R2 count loaded", count_o, 7'h25);
      idle(3 * DIV);
      chk("R2 frozen", count_o, 7'h25);
      chk("R2 stopped", running_o, 0);

      // R4 0xC0: request exactly DIV cycles later
      wr_ctrl(8'hC0);
      chk("R2 started", running_o, 1);
      idle(DIV - 1);
      chk("R4 no early pulse", sys_rst_req_o, 0);
      chk("R4 still 40", count_o, 7'h40);
      idle(1);
      chk("R4 underflow", sys_rst_req_o, 1);
      chk("R9 count cleared", count_o, 7'h7F);
      chk("R9 stopped", running_o, 0);
      idle(1);
      chk("R9 single cycle", sys_rst_req_o, 0);

      // R4 0xC8: nine ticks, R3 one step per DIV
      wr_ctrl(8'hC8);
      idle(DIV);
      chk("R3 first step", count_o, 7'h47);
      idle(8 * DIV - 1);
      chk("R4 nine ticks pending", sys_rst_req_o, 0);
      idle(1);
      chk("R4 nine ticks", sys_rst_req_o, 1);
      idle(1);

      // R7 default window, R8 sticky enable, R5 early reload
      wr_ctrl(8'hFF);
      wr_ctrl(8'hDB);
      chk("R7 refresh any time", sys_rst_req_o, 0);
      chk("R7 loaded", count_o, 7'h5B);
      wr_ctrl(8'h5B);
      chk("R8 still running", running_o, 1);
      wr_win(7'h4C);
      wr_ctrl(8'hDB);
      chk("R5 early reload", sys_rst_req_o, 1);
      idle(1);

      // R11 reload at the window boundary
      wr_win(7'h4C);
      wr_ctrl(8'hDB);
      idle(15 * DIV);
      chk("R11 at boundary", count_o, 7'h4C);
      chk("R11 window fn", in_window(count_o, 7'h4C), 1);
      wr_ctrl(8'hDB);
      chk("R11 accepted", sys_rst_req_o, 0);
      chk("R11 reloaded", count_o, 7'h5B);

      // R6 top bit cleared while running
      wr_ctrl(8'h9B);
      chk("R6 topbit write", sys_rst_req_o, 1);
      idle(1);

      // R10 write on the tick edge
      wr_ctrl(8'hC0);
      idle(DIV - 1);
      wr_ctrl(8'hC5);
      chk("R10 write wins", count_o, 7'h45);
      chk("R10 no underflow", sys_rst_req_o, 0);
      wr_ctrl(8'h80);
      chk("R6 clear", sys_rst_req_o, 1);
      idle(1);

      // constrained random phase, checked by the model each cycle
      for (int i = 0; i < 20000; i++) begin
         r = $urandom_range(0, 39);
         if (r == 0) begin
            v = 8'($urandom);
            wr_ctrl(v);
         end else if (r < 3) begin
            v = {2'b11, 6'($urandom)};
            wr_ctrl(v);
         end else if (r == 3 && in_window(m_cnt, m_win)) begin
            wr_ctrl({2'b11, 6'($urandom)});
         end else if (r == 4) begin
            wr_win({1'b1, 6'($urandom)});
         end else begin
            idle(1);
         end
      end
      idle(2);
      finish_run();
   end
endmodule